// File: doc/BRIEF.md
# Constant-Rate Table-Walk VLC Decoder

This block decodes prefix-free variable-length codes by walking a multi-way code tree held in an internal table. Each clock that a chunk of k stream bits is accepted, the chunk is joined with the current node base to form a table address. The entry read there either names the node base for the next step or reports a finished codeword. Here k is 1, 2 or 4 and is set by a rate input. The decoder takes one tree step per accepted chunk, so input advances at a fixed rate with no idle cycles while bits are offered and the symbol consumer keeps up.

When a codeword ends partway through a chunk, the block reports how many trailing bits of that chunk it did not use. In the same cycle the bit source rewinds by that many bits. After every finished codeword the walk restarts at node base 0. The table is loaded through a write port and can be reloaded to decode a different code. Loading is allowed only while the decoder is idle. A malformed entry stops decoding until reset.

Top module: `vlc_tree_decoder`

## Requirements
- R1: After reset, `sym_valid` and `dec_err` are 0, `in_ready` is 1, and the walk stands at node base 0.
- R2: While `dec_err` is 0 and `sym_ready` stays 1, `in_ready` stays 1, so one chunk is accepted in every cycle in which `in_valid` is 1.
- R3: Rate code 0, 1 and 2 selects k = 1, 2 and 4 bits per step. Stream bits sit in `in_bits[k-1:0]`, with the earliest bit in `in_bits[k-1]`. Bits above k-1 are ignored. The table address is `{node_base, chunk}`, where the chunk is zero-extended to 4 bits.
- R4: An entry of kind 2'b00 (bits [12:11]) is a branch. Its bits [4:0] become the node base for the next step.
- R5: An entry of kind 2'b01 is a leaf. Its symbol (bits [7:0]) appears on `sym_data` with `sym_valid` 1 after the accepting clock edge, and the walk returns to node base 0.
- R6: In the cycle a leaf step is accepted, `ret_valid` is 1 and `ret_count` equals the leaf's unused count (bits [10:8]). In all other cycles `ret_valid` is 0.
- R7: While `sym_valid` is 1 and `sym_ready` is 0, `sym_data` holds its value and `in_ready` is 0.
- R8: An entry of kind 2'b10 or 2'b11 sets `dec_err` after the accepting edge. `dec_err` then stays 1 and `in_ready` stays 0 until reset, and no symbol is produced.
- R9: A leaf whose unused count is not below k is treated as an error, exactly as in R8, with `ret_valid` 0.
- R10: A table write takes effect only when no walk is in progress, no symbol is pending and `in_valid` is 0. In any other cycle the write is ignored.
- R11: Rate code 3 behaves as rate code 2 (4 bits per step).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 2 | Bits per step: 0→1, 1→2, 2 and 3→4 |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 9 | Table write address {node_base, chunk} |
| tbl_data | input | 13 | Table entry {kind[1:0], payload[10:0]} |
| in_valid | input | 1 | Stream chunk offered |
| in_ready | output | 1 | Chunk accepted this cycle when valid |
| in_bits | input | 4 | Stream chunk, earliest bit at bit k-1 |
| ret_valid | output | 1 | A codeword ended in the accepted chunk |
| ret_count | output | 2 | Trailing bits of the chunk to give back |
| sym_valid | output | 1 | Decoded symbol available |
| sym_ready | input | 1 | Consumer takes the symbol |
| sym_data | output | 8 | Decoded symbol |
| dec_err | output | 1 | Sticky malformed-table flag |

## Verification
The hardest state to reach from the ports is a table write that arrives in the middle of a codeword, while the walk sits at a non-root node. The stimulus steps a single leading bit at rate 1 and then attempts to overwrite a root entry. It then finishes the codeword and decodes the root entry again, so any write that took effect shows up in the symbol. Random code streams are also replayed at every rate against the bench's own code table, with rewinds, input gaps and consumer stalls, so that leaves landing at every offset inside a chunk are covered.

// File: rtl/vlc_tree_pkg.sv
package vlc_tree_pkg;

  localparam int CHUNK_MAX = 4;

  typedef enum logic [1:0] {
    ENT_BRANCH = 2'b00,
    ENT_LEAF   = 2'b01,
    ENT_BAD_A  = 2'b10,
    ENT_BAD_B  = 2'b11
  } ent_kind_e;

  // number of stream bits consumed per step for a rate code
  function automatic logic [2:0] rate_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // mask keeping only the live bits of a chunk
  function automatic logic [CHUNK_MAX-1:0] chunk_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // a leaf may only give back fewer bits than the step consumed
  function automatic logic leaf_fits(input logic [2:0] unused, input logic [1:0] code);
    return unused < rate_bits(code);
  endfunction

endpackage

// File: rtl/vlc_table_ram.sv
module vlc_table_ram #(
  parameter int ADDR_W = 9,
  parameter int ENT_W  = 13
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [ENT_W-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [ENT_W-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read is combinational so the step completes in the accepting cycle
  assign rdata = mem[raddr];

endmodule

// File: rtl/vlc_walk_ctrl.sv
module vlc_walk_ctrl
  import vlc_tree_pkg::*;
#(
  parameter int NODE_W = 5,
  parameter int SYM_W  = 8,
  parameter int ENT_W  = 13
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  rate_sel,
  input  logic                        in_valid,
  input  logic [CHUNK_MAX-1:0]        in_bits,
  input  logic [ENT_W-1:0]            entry,
  input  logic                        out_room,
  output logic [NODE_W+CHUNK_MAX-1:0] rd_addr,
  output logic                        in_ready,
  output logic                        leaf_fire,
  output logic                        bad_fire,
  output logic [SYM_W-1:0]            leaf_sym,
  output logic                        ret_valid,
  output logic [1:0]                  ret_count,
  output logic                        mid_walk,
  output logic                        err
);
  logic [NODE_W-1:0]    node_q;
  logic                 mid_q;
  logic                 err_q;
  logic [CHUNK_MAX-1:0] chunk;
  ent_kind_e            kind;
  logic [2:0]           leaf_unused;
  logic [NODE_W-1:0]    next_base;
  logic                 step_fire;
  logic                 is_branch;
  logic                 is_leaf;
  logic                 branch_fire;

  assign chunk   = in_bits & chunk_mask(rate_sel);
  assign rd_addr = {node_q, chunk};

  always_comb begin
    kind        = ent_kind_e'(entry[ENT_W-1 -: 2]);
    leaf_unused = entry[SYM_W+2:SYM_W];
    leaf_sym    = entry[SYM_W-1:0];
    next_base   = entry[NODE_W-1:0];
    is_branch   = (kind == ENT_BRANCH);
    is_leaf     = (kind == ENT_LEAF) && leaf_fits(leaf_unused, rate_sel);
  end

  assign in_ready    = !err_q && out_room;
  assign step_fire   = in_valid && in_ready;
  assign branch_fire = step_fire && is_branch;
  assign leaf_fire   = step_fire && is_leaf;
  assign bad_fire    = step_fire && !is_branch && !is_leaf;
  assign ret_valid   = leaf_fire;
  assign ret_count   = leaf_unused[1:0];
  assign mid_walk    = mid_q;
  assign err         = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      node_q <= '0;
      mid_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (bad_fire) err_q <= 1'b1;
      if (leaf_fire) begin
        node_q <= '0;
        mid_q  <= 1'b0;
      end else if (branch_fire) begin
        node_q <= next_base;
        mid_q  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/vlc_sym_out.sv
module vlc_sym_out #(
  parameter int SYM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SYM_W-1:0] load_sym,
  input  logic             sym_ready,
  output logic             sym_valid,
  output logic [SYM_W-1:0] sym_data,
  output logic             room
);
  assign room = !sym_valid || sym_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_valid <= 1'b0;
      sym_data  <= '0;
    end else if (load) begin
      sym_valid <= 1'b1;
      sym_data  <= load_sym;
    end else if (sym_ready) begin
      sym_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/vlc_tree_decoder.sv
module vlc_tree_decoder
  import vlc_tree_pkg::*;
#(
  parameter int NODE_W = 5,
  parameter int SYM_W  = 8,
  localparam int ADDR_W = NODE_W + CHUNK_MAX,
  localparam int PAY_W  = (NODE_W > SYM_W + 3) ? NODE_W : SYM_W + 3,
  localparam int ENT_W  = PAY_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           rate_sel,
  input  logic                 tbl_we,
  input  logic [ADDR_W-1:0]    tbl_addr,
  input  logic [ENT_W-1:0]     tbl_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [CHUNK_MAX-1:0] in_bits,
  output logic                 ret_valid,
  output logic [1:0]           ret_count,
  output logic                 sym_valid,
  input  logic                 sym_ready,
  output logic [SYM_W-1:0]     sym_data,
  output logic                 dec_err
);
  logic [ADDR_W-1:0] rd_addr;
  logic [ENT_W-1:0]  entry;
  logic              out_room;
  logic              leaf_fire;
  logic              bad_fire;
  logic [SYM_W-1:0]  leaf_sym;
  logic              mid_walk;
  logic              busy;
  logic              wr_ok;

  // the table may change only between codewords with nothing in flight
  assign busy  = mid_walk || sym_valid || in_valid;
  assign wr_ok = tbl_we && !busy;

  vlc_table_ram #(.ADDR_W(ADDR_W), .ENT_W(ENT_W)) u_ram (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (tbl_addr),
    .wdata (tbl_data),
    .raddr (rd_addr),
    .rdata (entry)
  );

  vlc_walk_ctrl #(.NODE_W(NODE_W), .SYM_W(SYM_W), .ENT_W(ENT_W)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_sel  (rate_sel),
    .in_valid  (in_valid),
    .in_bits   (in_bits),
    .entry     (entry),
    .out_room  (out_room),
    .rd_addr   (rd_addr),
    .in_ready  (in_ready),
    .leaf_fire (leaf_fire),
    .bad_fire  (bad_fire),
    .leaf_sym  (leaf_sym),
    .ret_valid (ret_valid),
    .ret_count (ret_count),
    .mid_walk  (mid_walk),
    .err       (dec_err)
  );

  vlc_sym_out #(.SYM_W(SYM_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (leaf_fire),
    .load_sym  (leaf_sym),
    .sym_ready (sym_ready),
    .sym_valid (sym_valid),
    .sym_data  (sym_data),
    .room      (out_room)
  );

endmodule

// File: rtl/vlc_tree_decoder_checker.sv
module vlc_tree_decoder_checker
  import vlc_tree_pkg::*;
#(
  parameter int SYM_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       rate_sel,
  input logic             in_valid,
  input logic             in_ready,
  input logic             ret_valid,
  input logic [1:0]       ret_count,
  input logic             sym_valid,
  input logic             sym_ready,
  input logic [SYM_W-1:0] sym_data,
  input logic             dec_err,
  input logic             leaf_fire,
  input logic             bad_fire,
  input logic             mid_walk
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_data)));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |=> dec_err);

  assert_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> !in_ready);

  assert_bad_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_fire |=> (dec_err && !sym_valid));

  assert_ret_hs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> (in_valid && in_ready));

  assert_ret_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> ({1'b0, ret_count} < rate_bits(rate_sel)));

  assert_emit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    leaf_fire |=> sym_valid);

  assert_root_R5: assert property (@(posedge clk) disable iff (!rst_n)
    leaf_fire |=> !mid_walk);

endmodule

bind vlc_tree_decoder vlc_tree_decoder_checker #(.SYM_W(SYM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rate_sel  (rate_sel),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .ret_valid (ret_valid),
  .ret_count (ret_count),
  .sym_valid (sym_valid),
  .sym_ready (sym_ready),
  .sym_data  (sym_data),
  .dec_err   (dec_err),
  .leaf_fire (leaf_fire),
  .bad_fire  (bad_fire),
  .mid_walk  (mid_walk)
);

// File: tb/vlc_tree_decoder_bench.sv
module vlc_tree_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rate_sel = 2'd0;
  logic        tbl_we = 1'b0;
  logic [8:0]  tbl_addr = '0;
  logic [12:0] tbl_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_bits = '0;
  logic        ret_valid;
  logic [1:0]  ret_count;
  logic        sym_valid;
  logic        sym_ready = 1'b1;
  logic [7:0]  sym_data;
  logic        dec_err;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // code used by the bench: six codewords, MSB-first
  int cw_val [6] = '{0, 2, 6, 14, 30, 31};
  int cw_len [6] = '{1, 2, 3, 4, 5, 5};
  int cw_sym [6] = '{'h11, 'h22, 'h33, 'h44, 'h55, 'h66};

  bit   sbits [4096];
  int   bnd   [1024];
  int   exps  [1024];

  always #5 clk = ~clk;

  vlc_tree_decoder u_vlc_tree_decoder (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data), .in_valid(in_valid),
    .in_ready(in_ready), .in_bits(in_bits), .ret_valid(ret_valid),
    .ret_count(ret_count), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_data(sym_data), .dec_err(dec_err)
  );

  task automatic summary_and_end();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc);
      summary_and_end();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int kbits(input logic [1:0] code);
    return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [12:0] mk_leaf(input int unused, input int sym);
    return {2'b01, unused[2:0], sym[7:0]};
  endfunction

  function automatic logic [12:0] mk_branch(input int nxt);
    return {2'b00, 6'd0, nxt[4:0]};
  endfunction

  function automatic int match(input int s, input int len);
    for (int m = 0; m < 6; m++)
      if (cw_len[m] <= len && (s >> (len - cw_len[m])) == cw_val[m]) return m;
    return -1;
  endfunction

  task automatic wr(input int addr, input logic [12:0] data);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = addr[8:0]; tbl_data = data;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // build the k-ary tree for the bench code and write it to the table
  task automatic load_tables(input int k);
    int nv [32];
    int nl [32];
    int cnt = 1;
    nv[0] = 0; nl[0] = 0;
    for (int i = 0; i < cnt; i++) begin
      for (int c = 0; c < (1 << k); c++) begin
        int s = (nv[i] << k) | c;
        int len = nl[i] + k;
        int m = match(s, len);
        if (m >= 0) wr(i * 16 + c, mk_leaf(len - cw_len[m], cw_sym[m]));
        else begin
          nv[cnt] = s; nl[cnt] = len;
          wr(i * 16 + c, mk_branch(cnt));
          cnt++;
        end
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; tbl_we = 1'b0; sym_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one directed step: offer a chunk for one edge
  task automatic step(input logic [3:0] b, output bit fired, output bit rv, output int rc);
    @(negedge clk);
    in_valid = 1'b1; in_bits = b;
    #1;
    fired = in_ready; rv = ret_valid; rc = ret_count;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic run_stream(input logic [1:0] code, input int nsyms, input bit gaps, input bit bp, input string tag);
    int k = kbits(code);
    int total = 0;
    int ptr = 0;
    int got = 0;
    int sidx = 0;
    int loops = 0;
    int stalls = 0;
    rate_sel = code;
    load_tables(k);
    for (int j = 0; j < nsyms; j++) begin
      int m = (j == nsyms - 1) ? 0 : int'($urandom % 6);
      for (int b = cw_len[m] - 1; b >= 0; b--) begin
        sbits[total] = (cw_val[m] >> b) & 1;
        total++;
      end
      bnd[j] = total; exps[j] = cw_sym[m];
    end
    while (got < nsyms && loops < 30000) begin
      @(negedge clk);
      sym_ready = bp ? (($urandom % 4) != 0) : 1'b1;
      if (sym_valid && sym_ready) begin
        chk(sym_data == exps[got][7:0], {tag, " R5 symbol"}, sym_data, exps[got]);
        got++;
      end
      if (ptr < total) begin
        logic [3:0] ch = 4'($urandom);
        for (int i = 0; i < k; i++) ch[k-1-i] = (ptr + i < total) ? sbits[ptr + i] : 1'b0;
        in_valid = gaps ? (($urandom % 3) != 0) : 1'b1;
        in_bits = ch;
      end else in_valid = 1'b0;
      #1;
      if (in_valid && !in_ready) stalls++;
      if (in_valid && in_ready) begin
        if (bnd[sidx] <= ptr + k) begin
          int er = ptr + k - bnd[sidx];
          chk(ret_valid && ret_count == er[1:0], {tag, " R6 give-back"}, ret_valid ? ret_count : -1, er);
          ptr = bnd[sidx]; sidx++;
        end else begin
          chk(!ret_valid, {tag, " R6 no give-back mid-codeword"}, ret_valid, 0);
          ptr = ptr + k;
        end
      end
      loops++;
    end
    @(negedge clk);
    in_valid = 1'b0; sym_ready = 1'b1;
    chk(got == nsyms, {tag, " R3 all symbols decoded"}, got, nsyms);
    if (!gaps && !bp) chk(stalls == 0, {tag, " R2 no bubbles"}, stalls, 0);
  endtask

  initial begin
    bit f; bit rv; int rc;
    void'($urandom(32'd4242));
    do_reset();
    @(negedge clk);
    chk(!sym_valid, "R1 sym_valid after reset", sym_valid, 0);
    chk(!dec_err, "R1 dec_err after reset", dec_err, 0);
    chk(in_ready, "R1 in_ready after reset", in_ready, 1);

    run_stream(2'd0, 200, 1'b0, 1'b0, "rate1");
    run_stream(2'd1, 200, 1'b0, 1'b0, "rate2");
    run_stream(2'd2, 200, 1'b0, 1'b0, "rate4 R4");
    run_stream(2'd3, 150, 1'b0, 1'b0, "rate code3 R11");
    run_stream(2'd1, 200, 1'b1, 1'b1, "rate2 R7 backpressure");
    run_stream(2'd2, 200, 1'b1, 1'b1, "rate4 R7 backpressure");

    // R10: write during a walk is ignored, write while idle takes effect
    rate_sel = 2'd0;
    load_tables(1);
    step(4'b0001, f, rv, rc);
    chk(f && !rv, "R10 first step mid-codeword", rv, 0);
    wr(0, mk_leaf(0, 'hEE));
    step(4'b0000, f, rv, rc);
    chk(f && rv && rc == 0, "R10 finish codeword give-back", rc, 0);
    @(negedge clk);
    chk(sym_valid && sym_data == 8'h22, "R10 codeword after ignored write", sym_data, 'h22);
    step(4'b0000, f, rv, rc);
    @(negedge clk);
    chk(sym_valid && sym_data == 8'h11, "R10 root entry unchanged", sym_data, 'h11);
    wr(0, mk_leaf(0, 'hEE));
    step(4'b0000, f, rv, rc);
    @(negedge clk);
    chk(sym_valid && sym_data == 8'hEE, "R10 idle write applied", sym_data, 'hEE);

    // R9: leaf giving back as many bits as consumed
    @(negedge clk);
    rate_sel = 2'd1;
    wr(0, mk_leaf(2, 'h77));
    step(4'b0000, f, rv, rc);
    chk(f && !rv, "R9 oversize give-back not reported", rv, 0);
    @(negedge clk);
    chk(dec_err, "R9 error raised", dec_err, 1);
    chk(!sym_valid, "R9 no symbol", sym_valid, 0);

    // R8: malformed kind halts until reset
    do_reset();
    @(negedge clk);
    chk(!dec_err, "R1 error cleared by reset", dec_err, 0);
    rate_sel = 2'd0;
    wr(0, {2'b10, 11'd0});
    step(4'b0000, f, rv, rc);
    chk(f && !rv, "R8 bad entry accepted", rv, 0);
    @(negedge clk);
    in_valid = 1'b1; in_bits = 4'b0001;
    repeat (4) begin
      @(negedge clk);
      chk(dec_err && !in_ready && !sym_valid, "R8 halted", {dec_err, in_ready, sym_valid}, 4);
    end
    in_valid = 1'b0;
    do_reset();
    @(negedge clk);
    chk(!dec_err && in_ready, "R1 ready after second reset", {dec_err, in_ready}, 1);

    summary_and_end();
  end

endmodule